// File: doc/BRIEF.md
# Host-to-Controller Block-Transfer Mailbox

This block is a register-mapped mailbox that moves one message at a time between a management controller and a host. The controller sees a small word-addressed register file. It holds configuration, interrupt enable, interrupt status, a spare word, a handshake/control word, a byte-wide data port and an interrupt mask. Inbound bytes arrive on a simple byte stream that already has its framing removed. Outbound bytes are streamed out on a byte port when the controller signals that its message is ready.

The controller drives the handshake through writes to the control word. Each write performs a single action, picked by a fixed priority. When the controller reads the data port after a read-pointer clear, the first value returned is the inbound message length, and the payload bytes follow. A single level interrupt reports a completed inbound message and the start of an outbound transfer. Software acknowledges it by writing the status word.

Top module: `bt_mailbox`

## Requirements
- R1: After reset every register reads zero, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: The words at word addresses 0 (config), 1 (interrupt enable), 3 (spare) and 6 (mask) are plain 32-bit read/write storage.
- R3: The control word is at word address 4. Its read-back bits are 0x80 controller-busy, 0x40 host-busy, 0x08 outbound-attention and 0x04 inbound-attention. A write acts only on its highest-priority set bit, in the order 0x01 (clear write pointer), 0x02 (clear read pointer), 0x04 (clear inbound-attention), 0x80 (toggle controller-busy), 0x08 (start outbound).
- R4: A control write whose chosen action is 0x80 inverts the controller-busy flag.
- R5: A control write with none of the bits 0x8F set raises `bad_ctrl` for exactly the one cycle after the write.
- R6: The data port is at word address 5. After a read-pointer clear, the first read returns the inbound length. Later reads return the payload bytes in arrival order, and reads past the end return 0.
- R7: Inbound bytes and end-of-message strobes are taken only while `rx_ready` is high, which is while no message waits and controller-busy is clear. A byte beyond DEPTH marks the message as overflowed. An end-of-message on an overflowed or empty message has no effect.
- R8: An accepted end-of-message on a non-empty message sets inbound-attention. If enable bit 0 is set, it also sets status bit 0, raises `irq` and marks the message as waiting, which drops `rx_ready`.
- R9: After any control write that leaves controller-busy clear, the inbound length, overflow and waiting state are zero.
- R10: A data-port write appends its low byte to the outbound buffer while it holds fewer than DEPTH bytes. A write-pointer clear empties the buffer.
- R11: A start-outbound write sets host-busy and outbound-attention and streams the buffered bytes on `tx_byte`, one per cycle from the next cycle on, with `tx_last` on the final byte. Both flags clear one cycle after the stream ends. If enable bit 6 is set, status bit 6 is set and `irq` rises.
- R12: A write to the status word (word address 2) XORs the written value into it and drops `irq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_word | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| rx_valid | input | 1 | Inbound byte strobe |
| rx_byte | input | 8 | Inbound byte |
| rx_eom | input | 1 | Inbound end-of-message strobe |
| rx_ready | output | 1 | Inbound input is being accepted |
| tx_valid | output | 1 | Outbound byte valid |
| tx_byte | output | 8 | Outbound byte |
| tx_last | output | 1 | Final outbound byte |
| bad_ctrl | output | 1 | Control write selected no action |
| irq | output | 1 | Level interrupt |

## Verification
Every register access takes effect at the clock edge that ends its strobe cycle. Read data, `bad_ctrl`, `irq` and the handshake flags are therefore due on the falling edge right after that strobe, and the bench tasks return on exactly that edge before they sample. The first outbound byte is due on that same falling edge, with one new byte per following cycle. The bench checks each byte cycle by cycle and confirms `tx_valid` is low one cycle after the last byte. A status read issued directly after a start on an empty buffer still sees host-busy, because the flags last exactly one cycle in that case.

// File: rtl/bt_mailbox.sv
module bt_mailbox #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [2:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_eom,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  output logic        bad_ctrl,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  localparam logic [2:0] A_CFG = 3'd0, A_IEN = 3'd1, A_IST = 3'd2, A_SPR = 3'd3,
                         A_CTL = 3'd4, A_DAT = 3'd5, A_MSK = 3'd6;

  logic [31:0] cfg_q, ien_q, ist_q, spr_q, msk_q, rdata_q;
  logic        b_busy, h2b, xmit, irq_q, bad_q;
  logic        rx_wait, rx_ovf, rd_first;
  logic [LW-1:0] rx_len, rd_idx, tx_len, tx_cnt;
  logic [7:0]  rx_mem [DEPTH];
  logic [7:0]  tx_mem [DEPTH];

  wire wr_en  = reg_sel & reg_wr;
  wire rd_en  = reg_sel & ~reg_wr;
  wire ctl_wr = wr_en & (reg_word == A_CTL);
  wire [7:0] wd8 = reg_wdata[7:0];

  wire act_clrw = ctl_wr & wd8[0];
  wire act_clrr = ctl_wr & ~wd8[0] & wd8[1];
  wire act_h2b  = ctl_wr & (wd8[1:0] == 2'b00) & wd8[2];
  wire act_bb   = ctl_wr & (wd8[2:0] == 3'b000) & wd8[7];
  wire act_b2h  = ctl_wr & (wd8[2:0] == 3'b000) & ~wd8[7] & wd8[3];
  wire act_none = ctl_wr & ((wd8 & 8'h8F) == 8'h00);

  wire bb_next  = b_busy ^ act_bb;
  wire rx_rst   = ctl_wr & ~bb_next;
  wire start_tx = act_b2h & ~xmit;

  assign rx_ready = ~rx_wait & ~b_busy;
  wire eom_take = rx_eom & rx_ready & ~ctl_wr;
  wire rx_take  = rx_valid & ~rx_eom & rx_ready & ~ctl_wr;
  wire msg_done = eom_take & ~rx_ovf & (rx_len != '0);
  wire rx_store = rx_take & ~rx_ovf & (rx_len < FULL);
  wire tx_store = wr_en & (reg_word == A_DAT) & (tx_len < FULL);
  wire dat_rd   = rd_en & (reg_word == A_DAT);

  assign tx_valid  = xmit & (tx_cnt != tx_len);
  assign tx_byte   = tx_mem[tx_cnt[IW-1:0]];
  assign tx_last   = tx_valid & (tx_cnt == tx_len - LW'(1));
  assign reg_rdata = rdata_q;
  assign bad_ctrl  = bad_q;
  assign irq       = irq_q;

  wire [31:0] ctl_view = {24'd0, b_busy, xmit, 2'b00, xmit, h2b, 2'b00};

  always_ff @(posedge clk) begin
    if (rx_store) rx_mem[rx_len[IW-1:0]] <= rx_byte;
    if (tx_store) tx_mem[tx_len[IW-1:0]] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; ien_q <= '0; spr_q <= '0; msk_q <= '0;
    end else if (wr_en) begin
      case (reg_word)
        A_CFG: cfg_q <= reg_wdata;
        A_IEN: ien_q <= reg_wdata;
        A_SPR: spr_q <= reg_wdata;
        A_MSK: msk_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_busy <= 1'b0; h2b <= 1'b0; bad_q <= 1'b0;
    end else begin
      b_busy <= bb_next;
      bad_q  <= act_none;
      if (act_h2b) h2b <= 1'b0;
      else if (msg_done) h2b <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_len <= '0; rx_ovf <= 1'b0; rx_wait <= 1'b0;
    end else if (rx_rst) begin
      rx_len <= '0; rx_ovf <= 1'b0; rx_wait <= 1'b0;
    end else begin
      if (msg_done && ien_q[0]) rx_wait <= 1'b1;
      if (rx_store) rx_len <= rx_len + LW'(1);
      else if (rx_take && !rx_ovf) rx_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_first <= 1'b1; rd_idx <= '0;
    end else if (act_clrr) begin
      rd_first <= 1'b1;
    end else if (dat_rd) begin
      if (rd_first) begin
        rd_first <= 1'b0; rd_idx <= '0;
      end else if (rd_idx < rx_len) begin
        rd_idx <= rd_idx + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_len <= '0; tx_cnt <= '0; xmit <= 1'b0;
    end else begin
      if (act_clrw) tx_len <= '0;
      else if (tx_store) tx_len <= tx_len + LW'(1);
      if (start_tx) begin
        xmit <= 1'b1; tx_cnt <= '0;
      end else if (xmit) begin
        if (tx_cnt == tx_len) xmit <= 1'b0;
        else tx_cnt <= tx_cnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q <= '0; irq_q <= 1'b0;
    end else if (wr_en && reg_word == A_IST) begin
      ist_q <= ist_q ^ reg_wdata;
      irq_q <= 1'b0;
    end else begin
      if (msg_done && ien_q[0]) begin
        ist_q[0] <= 1'b1; irq_q <= 1'b1;
      end
      if (start_tx && ien_q[6]) begin
        ist_q[6] <= 1'b1; irq_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (reg_word)
        A_CFG: rdata_q <= cfg_q;
        A_IEN: rdata_q <= ien_q;
        A_IST: rdata_q <= ist_q;
        A_SPR: rdata_q <= spr_q;
        A_CTL: rdata_q <= ctl_view;
        A_MSK: rdata_q <= msk_q;
        A_DAT: begin
          if (rd_first) rdata_q <= {{(32-LW){1'b0}}, rx_len};
          else if (rd_idx < rx_len) rdata_q <= {24'd0, rx_mem[rd_idx[IW-1:0]]};
          else rdata_q <= '0;
        end
        default: rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bt_mailbox_chk.sv
module bt_mailbox_chk #(
  parameter int DEPTH = 64,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [2:0]    reg_word,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          tx_valid,
  input logic          hbusy,
  input logic          b_busy,
  input logic [LW-1:0] tx_len,
  input logic [LW-1:0] rx_len,
  input logic          bad_ctrl,
  input logic [31:0]   ist
);
  wire ctl_w = reg_sel & reg_wr & (reg_word == 3'd4);

  // R12
  ist_write_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_word == 3'd2) |=> !irq);

  // R11
  tx_within_hbusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> hbusy);

  // R10
  tx_fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len <= LW'(DEPTH));

  // R9
  rx_cleared_by_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w |=> (b_busy || rx_len == '0));

  // R5
  bad_ctrl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && (reg_wdata[7:0] & 8'h8F) == 8'h00) |=> bad_ctrl);

  // R4
  bbusy_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[2:0] == 3'b000 && reg_wdata[7]) |=> (b_busy != $past(b_busy)));

  // R8
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ist != '0));
endmodule

bind bt_mailbox bt_mailbox_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_word(reg_word), .reg_wdata(reg_wdata), .irq(irq),
  .tx_valid(tx_valid), .hbusy(xmit), .b_busy(b_busy),
  .tx_len(tx_len), .rx_len(rx_len), .bad_ctrl(bad_ctrl), .ist(ist_q)
);

// File: tb/sim_bt_mailbox.sv
module sim_bt_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0, rx_valid = 0, rx_eom = 0;
  logic [2:0] reg_word = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] rx_byte = 0, tx_byte;
  logic rx_ready, tx_valid, tx_last, bad_ctrl, irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  bt_mailbox u0 (.clk, .rst_n, .reg_sel, .reg_wr, .reg_word, .reg_wdata, .reg_rdata,
    .rx_valid, .rx_byte, .rx_eom, .rx_ready, .tx_valid, .tx_byte, .tx_last,
    .bad_ctrl, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] v);
    reg_sel = 1; reg_wr = 1; reg_word = a; reg_wdata = v;
    @(negedge clk); reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_sel = 1; reg_wr = 0; reg_word = a;
    @(negedge clk); reg_sel = 0; v = reg_rdata;
  endtask

  task automatic send(logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic eom();
    rx_eom = 1;
    @(negedge clk); rx_eom = 0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0); check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 1);
  endtask

  task automatic t_plain();
    wr(0, 32'hA5A5_0001); wr(1, 32'h0); wr(3, 32'hDEAD_BEEF); wr(6, 32'h1234_5678);
    rd(0, d); check("R2 cfg", d, 32'hA5A5_0001);
    rd(3, d); check("R2 spare", d, 32'hDEAD_BEEF);
    rd(6, d); check("R2 mask", d, 32'h1234_5678);
  endtask

  task automatic t_inbound();
    wr(1, 32'h1);
    send(8'h20); send(8'h31); send(8'h42); eom();
    check("R8 irq", irq, 1); check("R8 rx_ready", rx_ready, 0);
    rd(2, d); check("R8 status", d, 1);
    rd(4, d); check("R8 ctrl", d, 32'h04);
    wr(4, 32'h80); rd(4, d); check("R4 busy set", d, 32'h84);
    wr(4, 32'h04); rd(4, d); check("R3 h2b clear only", d, 32'h80);
    wr(4, 32'h02);
    rd(5, d); check("R6 length", d, 3);
    rd(5, d); check("R6 b0", d, 8'h20);
    rd(5, d); check("R6 b1", d, 8'h31);
    rd(5, d); check("R6 b2", d, 8'h42);
    rd(5, d); check("R6 past end", d, 0);
    wr(2, 32'h1); check("R12 irq low", irq, 0);
    rd(2, d); check("R12 status xor", d, 0);
    wr(2, 32'h2); rd(2, d); check("R12 xor sets", d, 2);
    wr(2, 32'h2);
    wr(4, 32'h80); rd(4, d); check("R4 busy clear", d, 0);
    check("R9 rx_ready", rx_ready, 1);
    wr(4, 32'h02); rd(5, d); check("R9 length zero", d, 0);
  endtask

  task automatic t_noirq_prio();
    wr(1, 32'h0);
    send(8'h77); send(8'h66); eom();
    check("R8 no irq", irq, 0); check("R8 ready kept", rx_ready, 1);
    rd(4, d); check("R8 h2b set", d, 32'h04);
    wr(4, 32'h84); rd(4, d); check("R3 prio h2b over busy", d, 0);
  endtask

  task automatic t_bad();
    wr(4, 32'h30); check("R5 bad pulse", bad_ctrl, 1);
    @(negedge clk); check("R5 bad one cycle", bad_ctrl, 0);
    wr(4, 32'h08); check("R5 no bad on action", bad_ctrl, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_empty_tx();
    wr(1, 32'h0);
    wr(5, 32'h11); wr(5, 32'h22);
    wr(4, 32'h81); rd(4, d); check("R3 clrw only", d, 0);
    wr(4, 32'h08); check("R10 emptied", tx_valid, 0);
    rd(4, d); check("R11 flags one cycle", d, 32'h48);
    rd(4, d); check("R11 flags cleared", d, 0);
    check("R11 no irq when disabled", irq, 0);
  endtask

  task automatic t_tx();
    wr(1, 32'h40); wr(4, 32'h01);
    wr(5, 32'h1A1); wr(5, 32'h2B2); wr(5, 32'h3C3);
    wr(4, 32'h08);
    check("R11 irq", irq, 1);
    for (int i = 0; i < 3; i++) begin
      check("R11 valid", tx_valid, 1);
      check("R11 byte", tx_byte, (i == 0) ? 8'hA1 : (i == 1) ? 8'hB2 : 8'hC3);
      check("R11 last", tx_last, (i == 2));
      @(negedge clk);
    end
    check("R11 stream end", tx_valid, 0);
    @(negedge clk);
    rd(4, d); check("R11 flags low", d, 0);
    rd(2, d); check("R11 status6", d, 32'h40);
    wr(2, 32'h40); check("R12 irq low", irq, 0);
    wr(1, 32'h0);
  endtask

  task automatic t_tx_full();
    wr(4, 32'h01);
    for (int i = 0; i < 66; i++) wr(5, 32'(i + 8'h10));
    wr(4, 32'h08);
    for (int i = 0; i < 64; i++) begin
      check("R10 full byte", {tx_valid, tx_byte}, {1'b1, 8'(i + 8'h10)});
      @(negedge clk);
    end
    check("R10 capped", tx_valid, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_overflow();
    wr(1, 32'h1);
    for (int i = 0; i < 65; i++) send(8'(i));
    eom();
    check("R7 overflow no irq", irq, 0);
    rd(4, d); check("R7 overflow no h2b", d, 0);
    wr(4, 32'h04);
    eom(); rd(4, d); check("R7 empty eom", d, 0);
    wr(4, 32'h80); check("R7 busy blocks", rx_ready, 0);
    send(8'h55); send(8'h56); eom();
    wr(4, 32'h02); rd(5, d); check("R7 ignored bytes", d, 0);
    check("R7 no irq while busy", irq, 0);
    wr(4, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_plain(); t_inbound(); t_noirq_prio(); t_bad();
    t_empty_tx(); t_tx(); t_tx_full(); t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule